// File: doc/BRIEF.md
# EPP Register Slave

This block sits on the peripheral side of a byte-wide parallel port. It gives a host access to a small bank of 16-bit registers. After reset the port stays in compatibility mode and ignores all strobes. The host first runs the enhanced-parallel-port negotiation handshake. Once that completes, the block serves address and data cycles. It acknowledges each host strobe with the busy line and releases it when the host lets go.

A register access is one address-write cycle followed by two data cycles. The low byte moves first and the high byte second. Writes are assembled and reach the internal register port as one single-cycle write pulse. Reads take a 16-bit snapshot from the internal read port and hand it out byte by byte. The bus is driven only during read strobes. Reading the sample register also produces a one-cycle pop pulse, so the data source behind it can advance.

All host lines pass through two-flop synchronisers before any logic uses them.

Top module: `epp_reg_slave`

## Requirements
- R1: After reset: epp_mode_o=0, data_oe_o=0, busy_o=0, ack_no=1, fault_no=1, perror_o=0, select_o=0, and reg_we_o and pop_o are both 0.
- R2: In compatibility mode, a negotiation request is selin_ni=1 and autofd_ni=0 with data 0x40. The block answers it with perror_o=1, ack_no=0, fault_no=1 and select_o=1. Any other data value gets no answer.
- R3: After the answer, the host pulses strobe_ni low and then raises strobe_ni and autofd_ni together. The block then enters EPP mode with ack_no=1, select_o=1 and perror_o=0. It stays in EPP mode until reset.
- R4: In EPP mode, selin_ni low is the address strobe. When strobe_ni is also low (write), the block latches the data byte as the register address. It raises busy_o, drops busy_o after the strobe is released, and resets the byte pointer to the low byte.
- R5: In EPP mode, autofd_ni low is the data strobe. With strobe_ni low the cycle is a write; with strobe_ni high it is a read. busy_o rises in answer and falls after release.
- R6: A 16-bit write arrives low byte first, then high byte. When the high byte is accepted, reg_we_o pulses for exactly one cycle with reg_wdata_o = {high, low}, provided the address is in 0x00..0x05.
- R7: Writes to any address above 0x05 produce no write pulse. This includes the sample register 0x08 and the error register 0x09.
- R8: On a read, data_oe_o is high only while the data strobe is active and busy_o is high. The low byte and the high byte both come from one snapshot of reg_rdata_i, taken when the low byte is requested.
- R9: After the high byte of a read of address 0x08 is released, pop_o pulses for one cycle. Reads of other addresses never pop.
- R10: If the address strobe and the data strobe are both active in the same idle cycle, the address cycle wins and no data is transferred.
- R11: Before EPP mode is entered, address and data strobes cause no busy_o, no write pulse and no bus drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Host data bus, input side |
| data_o | output | 8 | Read byte toward the host |
| data_oe_o | output | 1 | Bus drive enable for data_o |
| strobe_ni | input | 1 | Host write-low / read-high line, also used in negotiation |
| autofd_ni | input | 1 | Host data strobe, active low |
| selin_ni | input | 1 | Host address strobe, active low |
| busy_o | output | 1 | Strobe acknowledge / wait line |
| ack_no | output | 1 | Negotiation acknowledge, active low |
| perror_o | output | 1 | Negotiation status line |
| fault_no | output | 1 | Negotiation status line, active low |
| select_o | output | 1 | Negotiation select line |
| epp_mode_o | output | 1 | High once negotiation has completed |
| reg_addr_o | output | 8 | Internal register address |
| reg_wdata_o | output | 16 | Internal write data |
| reg_we_o | output | 1 | One-cycle internal write pulse |
| reg_rdata_i | input | 16 | Internal read data for reg_addr_o |
| pop_o | output | 1 | One-cycle advance pulse after a sample read |

## Verification
Two functions can land in the same idle cycle: the address strobe and the data strobe. The bench asserts selin_ni and autofd_ni on the same falling edge with a write address on the bus. It judges the result in two ways. First, no write pulse may appear. Second, two following data-only byte cycles must land at the newly latched address, which shows the address cycle won and the byte pointer restarted at the low byte. A related overlap is a change of reg_rdata_i between the two read bytes. The bench provokes it and expects the high byte from the earlier snapshot.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {
    NEG_COMPAT,
    NEG_REQ,
    NEG_STB,
    NEG_EPP
  } neg_state_e;

  typedef enum logic [1:0] {
    XF_IDLE,
    XF_ADDR,
    XF_DATA
  } xfer_state_e;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/epp_negotiator.sv
module epp_negotiator
  import epp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter logic [BYTE_W-1:0] REQ_CODE = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] data_s_i,
  input  logic              strobe_ns_i,
  input  logic              autofd_ns_i,
  input  logic              selin_ns_i,
  output logic              epp_mode_o,
  output logic              ack_no,
  output logic              perror_o,
  output logic              fault_no,
  output logic              select_o
);
  neg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      NEG_COMPAT: if (data_s_i == REQ_CODE && selin_ns_i && !autofd_ns_i) state_d = NEG_REQ;
      NEG_REQ:    if (!strobe_ns_i) state_d = NEG_STB;
      NEG_STB:    if (strobe_ns_i && autofd_ns_i) state_d = NEG_EPP;
      default:    state_d = NEG_EPP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= NEG_COMPAT;
    else         state_q <= state_d;
  end

  always_comb begin
    epp_mode_o = 1'b0;
    ack_no     = 1'b1;
    perror_o   = 1'b0;
    fault_no   = 1'b1;
    select_o   = 1'b0;
    unique case (state_q)
      NEG_REQ, NEG_STB: begin
        ack_no   = 1'b0;
        perror_o = 1'b1;
        select_o = 1'b1;
      end
      NEG_EPP: begin
        epp_mode_o = 1'b1;
        select_o   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/epp_xfer.sv
module epp_xfer
  import epp_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned RW_LAST     = 5,
  parameter int unsigned SAMPLE_ADDR = 8,
  localparam int unsigned REG_W      = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] data_s_i,
  input  logic              astb_i,
  input  logic              dstb_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  rdata_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o,
  output logic [BYTE_W-1:0] addr_o,
  output logic [REG_W-1:0]  wdata_o,
  output logic              we_o,
  output logic              pop_o
);
  xfer_state_e state_q;
  logic [BYTE_W-1:0] addr_q, lo_q;
  logic [REG_W-1:0]  snap_q, wdata_q;
  logic hi_q, rd_q, busy_q, we_q, pop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XF_IDLE;
      addr_q  <= '0;
      lo_q    <= '0;
      snap_q  <= '0;
      wdata_q <= '0;
      hi_q    <= 1'b0;
      rd_q    <= 1'b0;
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      pop_q   <= 1'b0;
    end else begin
      we_q  <= 1'b0;
      pop_q <= 1'b0;
      unique case (state_q)
        XF_IDLE: begin
          if (en_i && astb_i) begin
            // address strobe takes priority over a coincident data strobe
            busy_q  <= 1'b1;
            hi_q    <= 1'b0;
            if (wr_i) addr_q <= data_s_i;
            state_q <= XF_ADDR;
          end else if (en_i && dstb_i) begin
            busy_q  <= 1'b1;
            rd_q    <= !wr_i;
            state_q <= XF_DATA;
            if (wr_i) begin
              if (!hi_q) begin
                lo_q <= data_s_i;
              end else if (addr_q <= BYTE_W'(RW_LAST)) begin
                we_q    <= 1'b1;
                wdata_q <= {data_s_i, lo_q};
              end
            end else if (!hi_q) begin
              snap_q <= rdata_i;
            end
          end
        end
        XF_ADDR: begin
          if (!astb_i) begin
            busy_q  <= 1'b0;
            state_q <= XF_IDLE;
          end
        end
        XF_DATA: begin
          if (!dstb_i) begin
            busy_q  <= 1'b0;
            hi_q    <= !hi_q;
            pop_q   <= rd_q && hi_q && (addr_q == BYTE_W'(SAMPLE_ADDR));
            state_q <= XF_IDLE;
          end
        end
        default: state_q <= XF_IDLE;
      endcase
    end
  end

  assign data_o    = hi_q ? snap_q[REG_W-1:BYTE_W] : snap_q[BYTE_W-1:0];
  assign data_oe_o = (state_q == XF_DATA) && rd_q && dstb_i;
  assign busy_o    = busy_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign we_o      = we_q;
  assign pop_o     = pop_q;
endmodule

// File: rtl/epp_reg_slave.sv
module epp_reg_slave #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned RW_LAST     = 5,
  parameter int unsigned SAMPLE_ADDR = 8,
  parameter logic [BYTE_W-1:0] REQ_CODE = 8'h40,
  localparam int unsigned REG_W      = 2 * BYTE_W,
  localparam int unsigned SYNC_W     = BYTE_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic              strobe_ni,
  input  logic              autofd_ni,
  input  logic              selin_ni,
  output logic              busy_o,
  output logic              ack_no,
  output logic              perror_o,
  output logic              fault_no,
  output logic              select_o,
  output logic              epp_mode_o,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [REG_W-1:0]  reg_wdata_o,
  output logic              reg_we_o,
  input  logic [REG_W-1:0]  reg_rdata_i,
  output logic              pop_o
);
  logic [SYNC_W-1:0] raw, synced;
  logic [BYTE_W-1:0] data_s;
  logic strobe_ns, autofd_ns, selin_ns;

  assign raw = {data_i, strobe_ni, autofd_ni, selin_ni};

  epp_sync #(
    .W      (SYNC_W),
    .RST_VAL({{BYTE_W{1'b0}}, 3'b111})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign {data_s, strobe_ns, autofd_ns, selin_ns} = synced;

  epp_negotiator #(
    .BYTE_W  (BYTE_W),
    .REQ_CODE(REQ_CODE)
  ) u_neg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_s_i   (data_s),
    .strobe_ns_i(strobe_ns),
    .autofd_ns_i(autofd_ns),
    .selin_ns_i (selin_ns),
    .epp_mode_o (epp_mode_o),
    .ack_no     (ack_no),
    .perror_o   (perror_o),
    .fault_no   (fault_no),
    .select_o   (select_o)
  );

  epp_xfer #(
    .BYTE_W     (BYTE_W),
    .RW_LAST    (RW_LAST),
    .SAMPLE_ADDR(SAMPLE_ADDR)
  ) u_xfer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (epp_mode_o),
    .data_s_i (data_s),
    .astb_i   (!selin_ns),
    .dstb_i   (!autofd_ns),
    .wr_i     (!strobe_ns),
    .rdata_i  (reg_rdata_i),
    .data_o   (data_o),
    .data_oe_o(data_oe_o),
    .busy_o   (busy_o),
    .addr_o   (reg_addr_o),
    .wdata_o  (reg_wdata_o),
    .we_o     (reg_we_o),
    .pop_o    (pop_o)
  );
endmodule

// File: rtl/epp_reg_slave_chk.sv
module epp_reg_slave_chk #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned RW_LAST     = 5,
  parameter int unsigned SAMPLE_ADDR = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              epp_mode_o,
  input logic              busy_o,
  input logic              data_oe_o,
  input logic              reg_we_o,
  input logic              pop_o,
  input logic [BYTE_W-1:0] reg_addr_o
);
  AST_NO_BUSY_COMPAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epp_mode_o |-> (!busy_o && !reg_we_o && !data_oe_o)); // R11
  AST_MODE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epp_mode_o |=> epp_mode_o); // R3
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R6
  AST_WE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (reg_addr_o <= BYTE_W'(RW_LAST))); // R7
  AST_OE_UNDER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> busy_o); // R8
  AST_POP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !pop_o); // R9
  AST_POP_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> (reg_addr_o == BYTE_W'(SAMPLE_ADDR) && !busy_o)); // R9
endmodule

bind epp_reg_slave epp_reg_slave_chk #(
  .BYTE_W     (BYTE_W),
  .RW_LAST    (RW_LAST),
  .SAMPLE_ADDR(SAMPLE_ADDR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .epp_mode_o(epp_mode_o),
  .busy_o    (busy_o),
  .data_oe_o (data_oe_o),
  .reg_we_o  (reg_we_o),
  .pop_o     (pop_o),
  .reg_addr_o(reg_addr_o)
);

// File: tb/tb_epp_reg_slave.sv
module tb_epp_reg_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic strobe_n = 1'b1, autofd_n = 1'b1, selin_n = 1'b1;
  logic [7:0] data_o, reg_addr;
  logic data_oe, busy, ack_n, perror, fault_n, select, epp_mode, reg_we, pop;
  logic [15:0] reg_wdata, reg_rdata;

  int n_chk = 0, n_err = 0;
  int we_cnt = 0, pop_cnt = 0;
  bit done = 0;
  bit corrupt = 0;
  logic [15:0] regs [0:15];
  logic [15:0] sample_val = 16'h0A5C;
  logic [7:0]  last_waddr = 8'h00;

  always #10 clk = ~clk;

  epp_reg_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe),
    .strobe_ni(strobe_n), .autofd_ni(autofd_n), .selin_ni(selin_n), .busy_o(busy),
    .ack_no(ack_n), .perror_o(perror), .fault_no(fault_n), .select_o(select),
    .epp_mode_o(epp_mode), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata), .pop_o(pop)
  );

  // environment register model
  initial for (int i = 0; i < 16; i++) regs[i] = 16'h0000;
  always @(posedge clk) begin
    if (reg_we) begin
      regs[reg_addr[3:0]] <= reg_wdata;
      last_waddr <= reg_addr;
      we_cnt <= we_cnt + 1;
    end
    if (pop) begin
      sample_val <= sample_val + 16'd1;
      pop_cnt <= pop_cnt + 1;
    end
  end
  assign reg_rdata = corrupt ? 16'hFFFF : (reg_addr == 8'h08) ? sample_val : regs[reg_addr[3:0]];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_busy(logic lvl, string req);
    int t = 0;
    while (busy !== lvl && t < 100) begin
      @(negedge clk);
      t++;
    end
    if (busy !== lvl) check(req, busy, lvl);
  endtask

  task automatic host_addr(logic [7:0] a);
    @(negedge clk);
    data_i = a; strobe_n = 1'b0; selin_n = 1'b0;
    wait_busy(1'b1, "R4 addr ack");
    selin_n = 1'b1;
    wait_busy(1'b0, "R4 addr release");
  endtask

  task automatic host_wr(logic [7:0] b);
    @(negedge clk);
    data_i = b; strobe_n = 1'b0; autofd_n = 1'b0;
    wait_busy(1'b1, "R5 write ack");
    autofd_n = 1'b1;
    wait_busy(1'b0, "R5 write release");
  endtask

  task automatic host_rd(output logic [7:0] b, output logic oe);
    @(negedge clk);
    data_i = 8'h00; strobe_n = 1'b1; autofd_n = 1'b0;
    wait_busy(1'b1, "R5 read ack");
    b = data_o; oe = data_oe;
    autofd_n = 1'b1;
    wait_busy(1'b0, "R5 read release");
  endtask

  task automatic wr16(logic [7:0] a, logic [15:0] d);
    host_addr(a);
    host_wr(d[7:0]);
    host_wr(d[15:8]);
    tick(2);
  endtask

  task automatic rd16(logic [7:0] a, output logic [15:0] d, output logic oe_ok);
    logic [7:0] lo, hi;
    logic o1, o2;
    host_addr(a);
    host_rd(lo, o1);
    host_rd(hi, o2);
    tick(2);
    d = {hi, lo};
    oe_ok = o1 && o2 && !data_oe;
  endtask

  // op(1: write) | addr | data | expected (write: pulses, read: value)
  localparam int NV = 11;
  localparam logic [40:0] VEC [0:NV-1] = '{
    {1'b1, 8'h00, 16'h1234, 16'h0001},
    {1'b1, 8'h05, 16'hABCD, 16'h0001},
    {1'b1, 8'h08, 16'h5555, 16'h0000},
    {1'b1, 8'h09, 16'h7777, 16'h0000},
    {1'b1, 8'h06, 16'h1111, 16'h0000},
    {1'b0, 8'h00, 16'h0000, 16'h1234},
    {1'b0, 8'h05, 16'h0000, 16'hABCD},
    {1'b0, 8'h09, 16'h0000, 16'h0000},
    {1'b0, 8'h06, 16'h0000, 16'h0000},
    {1'b1, 8'h03, 16'h00FF, 16'h0001},
    {1'b0, 8'h03, 16'h0000, 16'h00FF}
  };

  initial begin
    logic [15:0] d;
    logic oe_ok, o1;
    logic [7:0] b;
    int w0, p0;

    tick(3);
    // R1 reset state
    check("R1 mode", epp_mode, 0);
    check("R1 oe", data_oe, 0);
    check("R1 busy", busy, 0);
    check("R1 lines", {ack_n, fault_n, perror, select}, 4'b1100);
    check("R1 pulses", {reg_we, pop}, 2'b00);
    rst_n = 1'b1;
    tick(3);

    // R11 strobes ignored before negotiation
    data_i = 8'h02; strobe_n = 1'b0; selin_n = 1'b0; autofd_n = 1'b0;
    tick(10);
    check("R11 busy", busy, 0);
    check("R11 we/oe", {reg_we, data_oe, epp_mode}, 3'b000);
    selin_n = 1'b1; autofd_n = 1'b1; strobe_n = 1'b1;
    tick(5);

    // R2 wrong request code
    data_i = 8'h41; autofd_n = 1'b0;
    tick(10);
    check("R2 no answer", {ack_n, perror}, 2'b10);
    autofd_n = 1'b1;
    tick(5);

    // R2 valid request
    data_i = 8'h40; autofd_n = 1'b0;
    tick(6);
    check("R2 answer", {perror, ack_n, fault_n, select}, 4'b1011);
    strobe_n = 1'b0;
    tick(6);
    check("R3 still answering", ack_n, 0);
    autofd_n = 1'b1; strobe_n = 1'b1;
    tick(6);
    check("R3 done", {ack_n, select, perror, epp_mode}, 4'b1101);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) begin
        w0 = we_cnt;
        wr16(VEC[i][39:32], VEC[i][31:16]);
        if (VEC[i][15:0] != 0) begin
          check($sformatf("R6 we count %0d", i), we_cnt - w0, 1);
          check($sformatf("R6 data %0d", i), regs[VEC[i][35:32]], VEC[i][31:16]);
        end else begin
          check($sformatf("R7 no we %0d", i), we_cnt - w0, 0);
        end
      end else begin
        p0 = pop_cnt;
        rd16(VEC[i][39:32], d, oe_ok);
        check($sformatf("R8 read %0d", i), d, VEC[i][15:0]);
        check($sformatf("R8 oe window %0d", i), oe_ok, 1);
        check($sformatf("R9 no pop %0d", i), pop_cnt - p0, 0);
      end
    end

    // R9 sample register reads pop once each
    p0 = pop_cnt;
    rd16(8'h08, d, oe_ok);
    check("R9 sample 1", d, 16'h0A5C);
    check("R9 pop count", pop_cnt - p0, 1);
    host_addr(8'h08);
    host_rd(b, o1);
    tick(3);
    check("R9 no pop after low byte", pop_cnt - p0, 1);
    host_rd(d[15:8], o1);
    tick(2);
    check("R9 sample advanced", {d[15:8], b}, 16'h0A5D);

    // R8 snapshot: source changes between bytes
    wr16(8'h02, 16'h2222);
    host_addr(8'h02);
    host_rd(b, o1);
    corrupt = 1'b1;
    host_rd(d[15:8], o1);
    corrupt = 1'b0;
    check("R8 snapshot", {d[15:8], b}, 16'h2222);

    // R10 simultaneous strobes: address wins
    w0 = we_cnt;
    @(negedge clk);
    data_i = 8'h04; strobe_n = 1'b0; selin_n = 1'b0; autofd_n = 1'b0;
    wait_busy(1'b1, "R10 ack");
    selin_n = 1'b1; autofd_n = 1'b1;
    wait_busy(1'b0, "R10 release");
    tick(3);
    check("R10 no data write", we_cnt - w0, 0);
    host_wr(8'hEE);
    host_wr(8'h0B);
    tick(2);
    check("R10 addr taken", last_waddr, 8'h04);
    check("R10 data", regs[4], 16'h0BEE);

    // R4 address cycle resets byte pointer after a lone low byte
    host_addr(8'h01);
    host_wr(8'h99);
    host_addr(8'h01);
    host_wr(8'h34);
    host_wr(8'h12);
    tick(2);
    check("R4 pointer reset", regs[1], 16'h1234);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule